// File: doc/BRIEF.md
# Edge-Armed One-Shot Pulse Generator

This block turns a slow level signal into a clean pulse of fixed length. When the input goes from low to high, the output goes high at the next rising clock edge. It stays high for exactly `PULSE_LEN` clock cycles. The block then stays quiet for as long as the input remains high. It fires again only after the input has been seen low for at least one clock edge and then rises once more. A long button press or a held enable therefore gives one pulse, not a train of pulses.

The controller is an explicit one-hot machine with one flip-flop per state:
- one armed state,
- a chain of `PULSE_LEN` pulse states,
- one state that waits for the input to go low.

The next-state logic of each state ORs one term for each transition that enters it. The output is registered and equals the OR of the pulse states.

The input must already be synchronous to `clk` and must change far more slowly than the clock.

Top module: `onehot_pulse_gen`

## Requirements
- R1: While `rst` is high, and at any time after reset while `trig_in` has stayed low, `pulse_out` is 0.
- R2: When `trig_in` is sampled high in the armed state, `pulse_out` is 1 from the very next rising clock edge on. In the cycle before that edge it is still 0.
- R3: Each pulse lasts exactly `PULSE_LEN` clock cycles, for `PULSE_LEN` values 1, 3 and 5.
- R4: Holding `trig_in` high for far longer than the pulse gives exactly one pulse.
- R5: After `trig_in` has been low for at least one clock edge, a new rising edge gives a new full-length pulse. One low cycle between two high stretches is enough.
- R6: If `trig_in` is high for a single clock cycle, the pulse still runs its full `PULSE_LEN` cycles.
- R7: The input is looked at only in the last pulse state. If `trig_in` falls and rises again while a pulse of `PULSE_LEN` ≥ 2 is still running, and is high in that last state, no second pulse is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; loads the armed state |
| trig_in | input | 1 | Synchronous level input whose rising edge triggers a pulse |
| pulse_out | output | 1 | Registered pulse, high for `PULSE_LEN` cycles per trigger |

## Verification
Three instances with pulse lengths 1, 3 and 5 are driven by the same input stimulus, and each is checked against its own expected values.

The input patterns are chosen so that each one separates a different wrong behaviour:
- A long hold separates an edge trigger from a level trigger.
- A hold, one low cycle, then a second hold shows that the block re-arms.
- A single-cycle spike shows that the pulse length is set by the chain and not by the input width.
- A low-high blip inside a running pulse shows that the machine looks at the input only when it leaves the last pulse state. For a length of 1 the same blip must yield two pulses, and for longer chains only one.

// File: rtl/pgen_pkg.sv
package pgen_pkg;

  // Slot of the armed state inside the one-hot vector.
  localparam int SLOT_ARMED = 0;

  // Slot of the wait-for-low state for a given pulse length.
  function automatic int slot_wait(input int pulse_len);
    return pulse_len + 1;
  endfunction

  // Width of the one-hot vector for a given pulse length.
  function automatic int state_width(input int pulse_len);
    return pulse_len + 2;
  endfunction

endpackage

// File: rtl/pgen_next.sv
module pgen_next #(
  parameter int PULSE_LEN = 3
) (
  input  logic [PULSE_LEN+1:0] st,
  input  logic                 trig,
  output logic [PULSE_LEN+1:0] nxt
);
  import pgen_pkg::*;

  localparam int ST_W     = state_width(PULSE_LEN);
  localparam int IDX_WAIT = slot_wait(PULSE_LEN);
  localparam int IDX_LAST = PULSE_LEN;
  localparam logic [ST_W-1:0] ARMED_CODE = {{(ST_W-1){1'b0}}, 1'b1};

  logic            legal;
  logic [ST_W-1:0] raw;

  assign legal = ($countones(st) == 1);

  // Armed: entered from armed, last pulse or wait, each with input low.
  assign raw[SLOT_ARMED] = ~trig & (st[SLOT_ARMED] | st[IDX_WAIT] | st[IDX_LAST]);

  // First pulse state: entered only from armed with input high.
  assign raw[1] = trig & st[SLOT_ARMED];

  // Remaining pulse states form an unconditional chain.
  generate
    for (genvar k = 2; k <= PULSE_LEN; k++) begin : g_chain
      assign raw[k] = st[k-1];
    end
  endgenerate

  // Wait-for-low: entered from the last pulse or from itself while the input is high.
  assign raw[IDX_WAIT] = trig & (st[IDX_WAIT] | st[IDX_LAST]);

  // Any vector with zero or several hot bits falls back to armed.
  assign nxt = legal ? raw : ARMED_CODE;

endmodule

// File: rtl/pgen_state_reg.sv
module pgen_state_reg #(
  parameter int PULSE_LEN = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PULSE_LEN+1:0] nxt,
  output logic [PULSE_LEN+1:0] st
);
  import pgen_pkg::*;

  localparam int ST_W = state_width(PULSE_LEN);
  localparam logic [ST_W-1:0] ARMED_CODE = {{(ST_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) st <= ARMED_CODE;
    else     st <= nxt;
  end

  // Exactly one state flip-flop is set outside reset (pulse chain integrity, R3).
  p_state_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot(st));

  // The register leaves reset holding the armed code (R1).
  p_reset_armed_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (st == ARMED_CODE));

endmodule

// File: rtl/pgen_out_reg.sv
module pgen_out_reg (
  input  logic clk,
  input  logic rst,
  input  logic pulse_nxt,
  output logic pulse_q
);

  always_ff @(posedge clk) begin
    if (rst) pulse_q <= 1'b0;
    else     pulse_q <= pulse_nxt;
  end

endmodule

// File: rtl/onehot_pulse_gen.sv
module onehot_pulse_gen #(
  parameter int PULSE_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_in,
  output logic pulse_out
);
  import pgen_pkg::*;

  localparam int ST_W     = state_width(PULSE_LEN);
  localparam int IDX_WAIT = slot_wait(PULSE_LEN);
  localparam int IDX_LAST = PULSE_LEN;
  localparam logic [ST_W-1:0] ARMED_CODE = {{(ST_W-1){1'b0}}, 1'b1};

  logic [ST_W-1:0] st;
  logic [ST_W-1:0] nxt;
  logic            pulse_nxt;

  pgen_next #(.PULSE_LEN(PULSE_LEN)) u_next (
    .st   (st),
    .trig (trig_in),
    .nxt  (nxt)
  );

  pgen_state_reg #(.PULSE_LEN(PULSE_LEN)) u_state (
    .clk (clk),
    .rst (rst),
    .nxt (nxt),
    .st  (st)
  );

  assign pulse_nxt = |nxt[IDX_LAST:1];

  pgen_out_reg u_out (
    .clk       (clk),
    .rst       (rst),
    .pulse_nxt (pulse_nxt),
    .pulse_q   (pulse_out)
  );

  // Output register agrees with the pulse states of the state register (R3).
  p_out_tracks_r3: assert property (@(posedge clk) disable iff (rst)
    pulse_out == (|st[IDX_LAST:1]));

  // Armed and input high: the pulse starts at the next edge (R2).
  p_arm_fire_r2: assert property (@(posedge clk) disable iff (rst)
    (st[SLOT_ARMED] && trig_in) |=> pulse_out);

  // A running pulse that is not yet in its last state keeps going (R6).
  p_chain_runs_r6: assert property (@(posedge clk) disable iff (rst)
    (pulse_out && !st[IDX_LAST]) |=> pulse_out);

  // Input still high in the wait state: no new pulse (R4).
  p_held_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (st[IDX_WAIT] && trig_in) |=> !pulse_out);

  // Input low in the wait state re-arms the machine (R5).
  p_rearm_r5: assert property (@(posedge clk) disable iff (rst)
    (st[IDX_WAIT] && !trig_in) |=> st[SLOT_ARMED]);

  // Last pulse state with input high leads to waiting, not firing (R7).
  p_last_high_waits_r7: assert property (@(posedge clk) disable iff (rst)
    (st[IDX_LAST] && trig_in) |=> st[IDX_WAIT]);

  // Illegal codes recover to the armed state at the next edge.
  p_illegal_recovers: assert property (@(posedge clk) disable iff (rst)
    ($countones(st) != 1) |=> (st == ARMED_CODE));

endmodule

// File: tb/tb_onehot_pulse_gen.sv
module tb_onehot_pulse_gen;

  localparam int NI = 3;
  localparam int LENS [NI] = '{1, 3, 5};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trig = 1'b0;
  logic [NI-1:0] outs;

  int checks = 0;
  int fails  = 0;
  int pulses  [NI];
  int cur_len [NI];
  int last_len[NI];
  logic [NI-1:0] prev_out = '0;

  always #10 clk = ~clk;  // 50 MHz

  onehot_pulse_gen #(.PULSE_LEN(1)) dut1 (.clk(clk), .rst(rst), .trig_in(trig), .pulse_out(outs[0]));
  onehot_pulse_gen #(.PULSE_LEN(3)) dut  (.clk(clk), .rst(rst), .trig_in(trig), .pulse_out(outs[1]));
  onehot_pulse_gen #(.PULSE_LEN(5)) dut5 (.clk(clk), .rst(rst), .trig_in(trig), .pulse_out(outs[2]));

  // Monitor: samples 5 ns after each rising edge.
  always @(posedge clk) begin
    #5;
    for (int i = 0; i < NI; i++) begin
      if (outs[i]) begin
        if (!prev_out[i]) begin
          pulses[i]++;
          cur_len[i] = 0;
        end
        cur_len[i]++;
      end else if (prev_out[i]) begin
        last_len[i] = cur_len[i];
      end
      prev_out[i] = outs[i];
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic clear_counts();
    for (int i = 0; i < NI; i++) begin
      pulses[i]   = 0;
      last_len[i] = 0;
    end
  endtask

  task automatic t_reset();
    cycles(2);
    check("R1 out during reset", int'(outs), 0);
    rst = 1'b0;
    clear_counts();
    cycles(6);
    for (int i = 0; i < NI; i++) check("R1 idle low no pulse", pulses[i], 0);
    check("R1 out idle", int'(outs), 0);
  endtask

  task automatic t_first_edge();
    clear_counts();
    trig = 1'b1;
    #1;
    check("R2 before edge", int'(outs), 0);
    @(posedge clk);
    #5;
    check("R2 after first edge", int'(outs), 7);
    @(negedge clk);
    cycles(9);
    trig = 1'b0;
    cycles(10);
  endtask

  task automatic t_width();
    clear_counts();
    trig = 1'b1;
    cycles(10);
    trig = 1'b0;
    cycles(10);
    for (int i = 0; i < NI; i++) begin
      check("R3 pulse width", last_len[i], LENS[i]);
      check("R3 one pulse", pulses[i], 1);
    end
  endtask

  task automatic t_held();
    clear_counts();
    trig = 1'b1;
    cycles(40);
    for (int i = 0; i < NI; i++) check("R4 held high single pulse", pulses[i], 1);
    check("R4 quiet while held", int'(outs), 0);
    trig = 1'b0;
    cycles(10);
  endtask

  task automatic t_rearm();
    clear_counts();
    trig = 1'b1;
    cycles(8);
    trig = 1'b0;
    cycles(1);
    trig = 1'b1;
    cycles(8);
    trig = 1'b0;
    cycles(10);
    for (int i = 0; i < NI; i++) begin
      check("R5 second pulse after low", pulses[i], 2);
      check("R5 second width", last_len[i], LENS[i]);
    end
  endtask

  task automatic t_spike();
    clear_counts();
    trig = 1'b1;
    cycles(1);
    trig = 1'b0;
    cycles(12);
    for (int i = 0; i < NI; i++) begin
      check("R6 spike pulse count", pulses[i], 1);
      check("R6 spike full width", last_len[i], LENS[i]);
    end
  endtask

  task automatic t_blip();
    clear_counts();
    trig = 1'b1;
    cycles(1);
    trig = 1'b0;
    cycles(1);
    trig = 1'b1;
    cycles(20);
    trig = 1'b0;
    cycles(10);
    for (int i = 0; i < NI; i++)
      check("R7 blip inside pulse", pulses[i], (LENS[i] >= 2) ? 1 : 2);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    clear_counts();
    for (int i = 0; i < NI; i++) cur_len[i] = 0;
    @(negedge clk);
    t_reset();
    t_first_edge();
    t_width();
    t_held();
    t_rearm();
    t_spike();
    t_blip();
    finish_run();
  end

  initial begin
    #(20 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule